// File: doc/BRIEF.md
# Four-Phase Sampling Time-to-Digital Channel

This block timestamps rising transitions on one asynchronous input with a resolution of a quarter clock period. Four clocks of the same frequency, spaced 90 degrees apart, each drive one sampling flip-flop. The four samples move through a short retiming chain into the 0-degree domain, where they form one four-bit vector for each clock period. A small state machine compares each vector with the last sample of the period before it. It finds the first 0-to-1 boundary and emits a one-cycle hit strobe. With the strobe it gives a stamp made of a 16-bit coarse period count and a 2-bit fine phase code. The clock period sets the bin width: at 360 MHz the four phases sample at 1.44 GHz, so one fine step is about 0.69 ns.

Each channel of a multi-channel time digitizer uses one copy of this block. All copies share the phase clocks. The fixed pipeline delay is removed from the coarse count, so the stamp names the period in which the edge was sampled rather than the period in which it is reported.

The encoder state machine has three states. `ST_FILL` is entered at reset and held for a fixed number of cycles while the retiming chain fills. No hits are reported in this state. When the fill count ends it moves to `ST_LINE_LOW` or `ST_LINE_HIGH`, chosen by the newest sample. `ST_LINE_LOW` means the last sample of the previous period was 0, and `ST_LINE_HIGH` means it was 1. In both of these states the next state follows the last (270-degree) bit of each new vector: a 1 leads to `ST_LINE_HIGH` and a 0 leads to `ST_LINE_LOW`.

Top module: `mts_tdc_channel`

## Requirements
- R1: While `rst` is high, and for the fill cycles after it falls, `hit_valid` stays low. An input already high when reset ends produces no hit.
- R2: The fine code `hit_stamp[1:0]` is the index of the first phase sample in the period that reads 1 (0 = 0 degrees, 1 = 90, 2 = 180, 3 = 270). An edge that arrives after the 270-degree sample is first seen by the next period's 0-degree sample and gives fine code 0 in that next period.
- R3: For an edge first sampled in period p, `hit_valid` is high during exactly period p+3.
- R4: An input that rises once and then stays high for many periods gives exactly one hit.
- R5: When more than one rising edge falls inside one period, only the earliest is reported, so there is at most one hit per period.
- R6: The coarse field `hit_stamp[17:2]` of two hits differs by the number of periods between their sampling periods, modulo 2^16.
- R7: Edges sampled in two consecutive periods give `hit_valid` in two consecutive cycles, each with its own stamp.
- R8: `hit_stamp` is cleared to 0 by reset and keeps its value in every cycle in which `hit_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0 | input | 1 | Main clock, 0-degree phase; all outputs are in this domain |
| clk90 | input | 1 | Same clock shifted by 90 degrees |
| clk180 | input | 1 | Same clock shifted by 180 degrees |
| clk270 | input | 1 | Same clock shifted by 270 degrees |
| rst | input | 1 | Synchronous active-high reset, sampled on clk0 |
| sig_in | input | 1 | Asynchronous input whose rising edges are timed |
| hit_valid | output | 1 | One-cycle strobe marking a new stamp |
| hit_stamp | output | 18 | Coarse period count (bits 17:2) and fine phase code (bits 1:0) |

## Verification
The bench places edges at offsets inside a period that fall in each of the four phase intervals. A swapped retiming stage or encoder priority would report the wrong fine code. An edge that lands after the last phase must be credited to the following period; a design that keeps it in the current period is off by one in coarse count and in latency. A pulse that drops and rises again inside one period must yield one hit with the earliest code, where a careless encoder would report the later edge or two hits. The bench also sends edges in adjacent periods, which catches a design that needs an idle cycle between hits. It holds the input high across reset, which catches one that reports a false hit at start-up. An idle stretch longer than 2^16 periods between two hits checks that the coarse difference wraps correctly.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
    localparam int unsigned PHASES  = 4;
    localparam int unsigned FINE_W  = $clog2(PHASES);

    typedef enum logic [1:0] {
        ST_FILL      = 2'd0,
        ST_LINE_LOW  = 2'd1,
        ST_LINE_HIGH = 2'd2
    } line_state_t;
endpackage

// File: rtl/phase_sampler.sv
module phase_sampler
    import tdc_pkg::*;
(
    input  logic              clk0,
    input  logic              clk90,
    input  logic              clk180,
    input  logic              clk270,
    input  logic              sig_in,
    output logic [PHASES-1:0] vec_o
);
    // first-level samples, one per phase domain
    logic smp0, smp90, smp180, smp270;
    // retiming stages
    logic hop270;
    logic al0, al90, al180;
    logic [PHASES-1:0] vec_q;

    always_ff @(posedge clk0)   smp0   <= sig_in;
    always_ff @(posedge clk90)  smp90  <= sig_in;
    always_ff @(posedge clk180) smp180 <= sig_in;
    always_ff @(posedge clk270) smp270 <= sig_in;

    // the latest phase takes a half-period hop before entering clk0
    always_ff @(posedge clk180) hop270 <= smp270;

    // early phases enter clk0; then one more stage lines all four up
    always_ff @(posedge clk0) begin
        al0   <= smp0;
        al90  <= smp90;
        al180 <= smp180;
        vec_q <= {hop270, al180, al90, al0};
    end

    assign vec_o = vec_q;
endmodule

// File: rtl/coarse_timer.sv
module coarse_timer #(
    parameter int unsigned COARSE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    output logic [COARSE_W-1:0] count_o
);
    logic [COARSE_W-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= count_q + 1'b1;
    end

    assign count_o = count_q;

    // R6: the period counter advances by one every cycle out of reset
    assert_count_step_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> count_q == COARSE_W'($past(count_q) + 1'b1));
endmodule

// File: rtl/edge_encoder.sv
module edge_encoder
    import tdc_pkg::*;
#(
    parameter int unsigned COARSE_W = 16,
    parameter int unsigned FILL_CYC = 3,
    parameter int unsigned LAT      = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [PHASES-1:0]          vec_i,
    input  logic [COARSE_W-1:0]        coarse_i,
    output logic                       hit_o,
    output logic [COARSE_W+FINE_W-1:0] stamp_o
);
    localparam int unsigned FILL_W = $clog2(FILL_CYC + 1);

    line_state_t        state, state_nxt;
    logic [FILL_W-1:0]  fill_cnt;
    logic [PHASES-1:0]  rise;
    logic [FINE_W-1:0]  fine_d;
    logic               hit_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_FILL;
            fill_cnt <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_FILL) fill_cnt <= fill_cnt + 1'b1;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_FILL: begin
                if (fill_cnt == FILL_W'(FILL_CYC - 1))
                    state_nxt = vec_i[PHASES-1] ? ST_LINE_HIGH : ST_LINE_LOW;
            end
            ST_LINE_LOW, ST_LINE_HIGH: begin
                state_nxt = vec_i[PHASES-1] ? ST_LINE_HIGH : ST_LINE_LOW;
            end
            default: state_nxt = ST_FILL;
        endcase
    end

    // outputs: earliest 0->1 boundary, the previous period's last bit below bit 0
    always_comb begin
        rise   = vec_i & ~{vec_i[PHASES-2:0], (state == ST_LINE_HIGH)};
        fine_d = '0;
        for (int k = PHASES - 1; k >= 0; k--) begin
            if (rise[k]) fine_d = FINE_W'(k);
        end
        hit_d = (state != ST_FILL) && (rise != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hit_o   <= 1'b0;
            stamp_o <= '0;
        end else begin
            hit_o <= hit_d;
            if (hit_d) stamp_o <= {coarse_i - COARSE_W'(LAT), fine_d};
        end
    end

    // R1: nothing is reported while the retiming chain fills
    assert_quiet_fill_R1: assert property (@(posedge clk) disable iff (rst)
        $past(state == ST_FILL) |-> !hit_o);

    // R2: the reported phase saw a 1 in the vector that produced the hit
    assert_fine_bit_set_R2: assert property (@(posedge clk) disable iff (rst)
        hit_o |-> ((($past(vec_i) >> stamp_o[FINE_W-1:0]) & PHASES'(1)) != '0));

    // R5: the phase just before the reported one was 0, so the earliest edge wins
    assert_earliest_edge_R5: assert property (@(posedge clk) disable iff (rst)
        (hit_o && stamp_o[FINE_W-1:0] != '0) |->
        ((($past(vec_i) >> (stamp_o[FINE_W-1:0] - 1'b1)) & PHASES'(1)) == '0));

    // R2: fine code 0 only when the previous period ended low
    assert_boundary_edge_R2: assert property (@(posedge clk) disable iff (rst)
        (hit_o && stamp_o[FINE_W-1:0] == '0) |-> $past(state) == ST_LINE_LOW);
endmodule

// File: rtl/mts_tdc_channel.sv
module mts_tdc_channel
    import tdc_pkg::*;
#(
    parameter int unsigned COARSE_W = 16
) (
    input  logic                       clk0,
    input  logic                       clk90,
    input  logic                       clk180,
    input  logic                       clk270,
    input  logic                       rst,
    input  logic                       sig_in,
    output logic                       hit_valid,
    output logic [COARSE_W+FINE_W-1:0] hit_stamp
);
    // vector is ready two clk0 edges after its period; the encoder adds one register
    localparam int unsigned PIPE_LAT = 2;
    localparam int unsigned FILL_CYC = PIPE_LAT + 1;

    logic [PHASES-1:0]   vec;
    logic [COARSE_W-1:0] coarse;

    phase_sampler u_sampler (
        .clk0   (clk0),
        .clk90  (clk90),
        .clk180 (clk180),
        .clk270 (clk270),
        .sig_in (sig_in),
        .vec_o  (vec)
    );

    coarse_timer #(.COARSE_W(COARSE_W)) u_timer (
        .clk     (clk0),
        .rst     (rst),
        .count_o (coarse)
    );

    edge_encoder #(
        .COARSE_W (COARSE_W),
        .FILL_CYC (FILL_CYC),
        .LAT      (PIPE_LAT)
    ) u_encoder (
        .clk      (clk0),
        .rst      (rst),
        .vec_i    (vec),
        .coarse_i (coarse),
        .hit_o    (hit_valid),
        .stamp_o  (hit_stamp)
    );

    // R8: the stamp only moves together with a strobe
    assert_stamp_hold_R8: assert property (@(posedge clk0) disable iff (rst)
        !hit_valid |-> $stable(hit_stamp));
endmodule

// File: tb/mts_tdc_channel_tb_top.sv
module mts_tdc_channel_tb_top;
    localparam int HALF  = 5000;   // ps, 100 MHz
    localparam int QUART = 2500;
    localparam int NVEC  = 8;
    // stimulus: edge offset inside a period in 0.5 ns steps; expected fine code and period shift
    localparam int OFFS  [NVEC] = '{2, 7, 12, 17, 4, 14, 9, 19};
    localparam int EFINE [NVEC] = '{1, 2, 3, 0, 1, 3, 2, 0};
    localparam int ESHFT [NVEC] = '{0, 0, 0, 1, 0, 0, 0, 1};

    logic clk0 = 1'b0, clk90 = 1'b0;
    logic clk180, clk270;
    logic rst = 1'b1;
    logic sig_in = 1'b0;
    logic        hit_valid;
    logic [17:0] hit_stamp;

    assign clk180 = ~clk0;
    assign clk270 = ~clk90;

    initial forever #HALF clk0 = ~clk0;
    initial begin #QUART; forever #HALF clk90 = ~clk90; end

    mts_tdc_channel dut_i (
        .clk0(clk0), .clk90(clk90), .clk180(clk180), .clk270(clk270),
        .rst(rst), .sig_in(sig_in), .hit_valid(hit_valid), .hit_stamp(hit_stamp)
    );

    int cyc = 0;
    int n_chk = 0, n_fail = 0;
    int nhits = 0;
    int hc [8];
    logic [17:0] hs [8];
    bit done = 0;

    always @(posedge clk0) cyc <= cyc + 1;

    always @(negedge clk0) begin
        if (!rst && hit_valid) begin
            hc[nhits % 8] = cyc;
            hs[nhits % 8] = hit_stamp;
            nhits++;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic rise_at(input int off, output int per);
        @(posedge clk0);
        #1;
        per = cyc + ((off >= 15) ? 1 : 0);
        #(off * 500 - 1);
        sig_in = 1'b1;
    endtask

    task automatic fall_at(input int off);
        @(posedge clk0);
        #(off * 500);
        sig_in = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk0);
    endtask

    function automatic int last_cyc(input int back);
        return hc[(nhits - 1 - back) % 8];
    endfunction

    function automatic logic [17:0] last_stamp(input int back);
        return hs[(nhits - 1 - back) % 8];
    endfunction

    initial begin
        int prev_p, p, h0, p1, p2;
        logic [17:0] held;
        prev_p = 0;

        // reset with the input already high
        sig_in = 1'b1;
        settle(4);
        #1000;
        check(hit_valid == 1'b0, "R1 valid during reset", int'(hit_valid), 0);
        @(posedge clk0); #1; rst = 1'b0;
        settle(8);
        #1000;
        check(nhits == 0, "R1 no hit for level high at reset end", nhits, 0);
        check(hit_stamp == 18'd0, "R8 stamp cleared by reset", int'(hit_stamp), 0);
        sig_in = 1'b0;
        settle(4);

        // vector walk over offsets in every phase interval
        for (int i = 0; i < NVEC; i++) begin
            h0 = nhits;
            rise_at(OFFS[i], p);
            settle(5);
            fall_at(1);
            settle(5);
            check(nhits == h0 + 1, "R4 one hit per edge", nhits - h0, 1);
            check(last_cyc(0) == p + 3, "R3 hit latency", last_cyc(0) - p, 3);
            check(int'(last_stamp(0)[1:0]) == EFINE[i], "R2 fine code",
                  int'(last_stamp(0)[1:0]), EFINE[i]);
            if (i > 0)
                check(int'(last_stamp(0)[17:2] - last_stamp(1)[17:2]) == ((p - prev_p) & 16'hffff),
                      "R6 coarse difference",
                      int'(16'(last_stamp(0)[17:2] - last_stamp(1)[17:2])), (p - prev_p) & 16'hffff);
            if (ESHFT[i] == 1)
                check(p == last_cyc(0) - 3, "R2 late edge moves to next period", last_cyc(0) - 3, p);
            prev_p = p;
        end

        // R8: stamp held while idle
        held = hit_stamp;
        settle(20);
        #1000;
        check(hit_stamp == held, "R8 stamp held between hits", int'(hit_stamp), int'(held));

        // R5: 0 1 0 1 inside one period
        h0 = nhits;
        @(posedge clk0); #1; p = cyc;
        #999  sig_in = 1'b1;
        #3000 sig_in = 1'b0;
        #2000 sig_in = 1'b1;
        settle(4);
        fall_at(1);
        settle(5);
        check(nhits == h0 + 1, "R5 second edge in period ignored", nhits - h0, 1);
        check(int'(last_stamp(0)[1:0]) == 1, "R5 earliest phase reported", int'(last_stamp(0)[1:0]), 1);

        // R7: edges in adjacent periods
        h0 = nhits;
        @(posedge clk0); #1; p = cyc;
        #999 sig_in = 1'b1;
        @(posedge clk0);
        #1000 sig_in = 1'b0;
        #5000 sig_in = 1'b1;
        settle(4);
        fall_at(1);
        settle(5);
        check(nhits == h0 + 2, "R7 two hits", nhits - h0, 2);
        check(last_cyc(0) == last_cyc(1) + 1, "R7 consecutive strobes", last_cyc(0) - last_cyc(1), 1);
        check(last_cyc(1) == p + 3, "R7 first hit latency", last_cyc(1) - p, 3);
        check(int'(last_stamp(0)[1:0]) == 3, "R7 second fine code", int'(last_stamp(0)[1:0]), 3);
        check(int'(16'(last_stamp(0)[17:2] - last_stamp(1)[17:2])) == 1, "R7 coarse step",
              int'(16'(last_stamp(0)[17:2] - last_stamp(1)[17:2])), 1);

        // R6: wrap of the coarse count across a long idle stretch
        rise_at(4, p1);
        settle(3);
        fall_at(1);
        settle(65540);
        rise_at(12, p2);
        settle(3);
        fall_at(1);
        settle(5);
        check(int'(16'(last_stamp(0)[17:2] - last_stamp(1)[17:2])) == ((p2 - p1) & 16'hffff),
              "R6 coarse wrap", int'(16'(last_stamp(0)[17:2] - last_stamp(1)[17:2])),
              (p2 - p1) & 16'hffff);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(64'd1500000000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule